// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Unit

This block runs the load-reserved (LR) and store-conditional (SC) atomic instructions for one hart. The issue stage gives it one instruction word, the two source operand values and the address translation already done for the operand address. The unit decodes the instruction and checks alignment. It then either finishes at once with an exception or a store-conditional failure code, or it makes exactly one memory request over a valid/ready handshake and waits for the response. The outcome comes back as a one-cycle done pulse. That pulse carries either a destination-register write or an exception code.

A single reservation (a valid flag plus an address) links an LR to a later SC. The reservation is keyed on the virtual address from the first source operand, not on the translated address. A successful SC clears it. The trap logic can also drop it at any time, on trap entry or on a return from a privileged handler. An SC whose address does not hit the reservation writes 1 to its destination and makes no memory access. The ordering bits (aq, rl) are copied onto the memory request and have no other effect.

Top module: `lrsc_unit`

## Requirements
- R1: An instruction is executed only when opcode[6:0] = 0101111, bits [31:27] = 00010 (LR, with bits [24:20] all zero) or 00011 (SC), and bits [14:12] = 010 (word) or 011 (doubleword). Any other word ends with exception code 2, no destination write and no memory request.
- R2: Alignment is checked before the translation result is used. A word access needs address bits [1:0] = 0 and a doubleword access needs bits [2:0] = 0. A misaligned LR or SC ends with exception code 6, even when translation also faulted. It makes no memory request and leaves the reservation as it was.
- R3: An aligned, legal instruction whose translation reports a fault ends with exception code equal to `xlat_code_i`. It makes no destination write and no memory request.
- R4: An LR makes one read request to the translated address, with `mem_req_dword_o` = 1 for doubleword. The destination receives all 64 response bits for a doubleword, or response bits [31:0] sign-extended to 64 bits for a word. The reservation is then set to the virtual address, so a later SC to the same virtual address hits even when it translates to a different physical address.
- R5: An SC whose virtual address is not the held reservation, or that finds no reservation, writes 1 to the destination, raises no exception and makes no memory request. A failed SC leaves the reservation as it was.
- R6: An SC that hits the reservation makes one write request to the translated address. The write data is the whole of rs2 for a doubleword, or rs2[31:0] with the upper 32 bits zero for a word. On a fault-free response the destination receives 0 and the reservation is cleared.
- R7: A response with `mem_rsp_fault_i` = 1 ends the instruction with exception code 5 for an LR or 7 for an SC. The destination is not written and the reservation is unchanged.
- R8: A cycle with `trap_entry_i` or `xret_i` high clears the reservation. This wins over an LR that would set the reservation in the same cycle.
- R9: After reset no reservation is held, and the unit is idle with no request and no done pulse.
- R10: A request stays valid, with address, data, direction, size, aq and rl unchanged, until `mem_req_ready_i` is high. `mem_req_aq_o` and `mem_req_rl_o` carry instruction bits 26 and 25.
- R11: Each accepted instruction gives exactly one single-cycle `done_o` pulse, and `rd_we_o`/`exc_valid_o` are high only in that cycle. `start_i` is ignored while `busy_o` is high. An instruction that needs no memory access signals done in the cycle after it is accepted. One that does signals done in the cycle after its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Present an instruction (taken when idle) |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | First operand: virtual address |
| rs2_val_i | input | 64 | Second operand: store data |
| xlat_fault_i | input | 1 | Translation of rs1 failed |
| xlat_code_i | input | 5 | Exception code to raise on translation failure |
| xlat_paddr_i | input | 64 | Translated address |
| trap_entry_i | input | 1 | Trap (exception or interrupt) taken |
| xret_i | input | 1 | Return from a privileged handler to a lower level |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_dword_o | output | 1 | 1 = doubleword, 0 = word |
| mem_req_addr_o | output | 64 | Translated address |
| mem_req_wdata_o | output | 64 | Write data |
| mem_req_aq_o | output | 1 | Acquire bit copied from the instruction |
| mem_req_rl_o | output | 1 | Release bit copied from the instruction |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_fault_i | input | 1 | Response reports an access fault |
| mem_rsp_rdata_i | input | 64 | Read data (a word in bits [31:0]) |
| busy_o | output | 1 | An instruction is in progress |
| done_o | output | 1 | Instruction finished this cycle |
| rd_we_o | output | 1 | Write destination register |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Destination value |
| exc_valid_o | output | 1 | Instruction ends with an exception |
| exc_code_o | output | 5 | Exception code |

## Verification
The bench targets the places where a near-miss design still looks plausible. It gives an LR and an SC the same virtual address but different translated addresses; a design keyed on the physical address would fail that SC. It sends a misaligned access with a translation fault as well; a design that tested translation first would report the wrong code. It checks that a word LR with bit 31 set is sign-extended and that a word SC zeroes the upper store bits. It repeats an SC after a success, a trap, a privileged return and a faulted write, to expose a reservation that is kept or dropped at the wrong moment. It stalls the handshake, and while the unit is busy it pokes `start_i`, which must not cause a second done pulse.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int EXC_W = 5;

  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [4:0] F5_LOADRES = 5'b00010;
  localparam logic [4:0] F5_STORECOND = 5'b00011;
  localparam logic [2:0] SZ_WORD = 3'b010;
  localparam logic [2:0] SZ_DWORD = 3'b011;

  localparam logic [EXC_W-1:0] EXC_ILLEGAL = 5'd2;
  localparam logic [EXC_W-1:0] EXC_LOAD_FAULT = 5'd5;
  localparam logic [EXC_W-1:0] EXC_AMO_MISALIGN = 5'd6;
  localparam logic [EXC_W-1:0] EXC_AMO_FAULT = 5'd7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic       legal;
    logic       is_sc;
    logic       dword;
    logic       aq;
    logic       rl;
    logic       misal;
    logic [4:0] rd;
  } dec_t;
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode #(
  parameter int XLEN = 64
) (
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  vaddr_i,
  output lrsc_pkg::dec_t   dec_o
);
  import lrsc_pkg::*;

  logic       op_ok;
  logic       lr_form;
  logic       sc_form;
  logic       size_ok;
  logic [2:0] align_mask;

  always_comb begin
    op_ok   = (instr_i[6:0] == OPC_ATOMIC);
    lr_form = op_ok && (instr_i[31:27] == F5_LOADRES) && (instr_i[24:20] == 5'd0);
    sc_form = op_ok && (instr_i[31:27] == F5_STORECOND);
    size_ok = (instr_i[14:12] == SZ_WORD) || (instr_i[14:12] == SZ_DWORD);

    case (instr_i[13:12])
      2'b00:   align_mask = 3'b000;
      2'b01:   align_mask = 3'b001;
      2'b10:   align_mask = 3'b011;
      default: align_mask = 3'b111;
    endcase

    dec_o.legal = (lr_form || sc_form) && size_ok;
    dec_o.is_sc = sc_form;
    dec_o.dword = instr_i[12];
    dec_o.aq    = instr_i[26];
    dec_o.rl    = instr_i[25];
    dec_o.misal = |(vaddr_i[2:0] & align_mask);
    dec_o.rd    = instr_i[11:7];
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          clr_i,
  input  logic [AW-1:0] probe_addr_i,
  output logic          hit_o,
  output logic          valid_o
);
  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q;

  always_comb begin
    valid_d = valid_q;
    if (set_i) valid_d = 1'b1;
    if (clr_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (set_i) begin
      addr_q <= set_addr_i;
    end
  end

  assign hit_o   = valid_q && (addr_q == probe_addr_i);
  assign valid_o = valid_q;
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit #(
  parameter int XLEN = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [31:0]                instr_i,
  input  logic [XLEN-1:0]            rs1_val_i,
  input  logic [XLEN-1:0]            rs2_val_i,
  input  logic                       xlat_fault_i,
  input  logic [lrsc_pkg::EXC_W-1:0] xlat_code_i,
  input  logic [XLEN-1:0]            xlat_paddr_i,
  input  logic                       trap_entry_i,
  input  logic                       xret_i,
  output logic                       mem_req_valid_o,
  input  logic                       mem_req_ready_i,
  output logic                       mem_req_write_o,
  output logic                       mem_req_dword_o,
  output logic [XLEN-1:0]            mem_req_addr_o,
  output logic [XLEN-1:0]            mem_req_wdata_o,
  output logic                       mem_req_aq_o,
  output logic                       mem_req_rl_o,
  input  logic                       mem_rsp_valid_i,
  input  logic                       mem_rsp_fault_i,
  input  logic [XLEN-1:0]            mem_rsp_rdata_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       rd_we_o,
  output logic [4:0]                 rd_idx_o,
  output logic [XLEN-1:0]            rd_data_o,
  output logic                       exc_valid_o,
  output logic [lrsc_pkg::EXC_W-1:0] exc_code_o
);
  import lrsc_pkg::*;

  localparam int UPPER_W = XLEN - 32;

  state_e            state_q, state_d;
  dec_t              dec;
  logic              accept;
  logic              resv_hit;
  logic              resv_valid;
  logic              resv_set;
  logic              resv_clr;
  logic              sc_ok;

  // Operation capture, loaded on accept
  logic [XLEN-1:0]   vaddr_q, paddr_q, wdata_q;
  logic              is_sc_q, dword_q, aq_q, rl_q;
  logic [4:0]        rd_q;
  logic [XLEN-1:0]   wdata_d;

  // Result registers, loaded when the outcome is known
  logic              res_en;
  logic              res_we_q, res_we_d;
  logic              exc_q, exc_d;
  logic [EXC_W-1:0]  code_q, code_d;
  logic [XLEN-1:0]   data_q, data_d;

  lrsc_decode #(.XLEN(XLEN)) u_decode (
    .instr_i (instr_i),
    .vaddr_i (rs1_val_i),
    .dec_o   (dec)
  );

  lrsc_resv #(.AW(XLEN)) u_resv (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_i        (resv_set),
    .set_addr_i   (vaddr_q),
    .clr_i        (resv_clr),
    .probe_addr_i (rs1_val_i),
    .hit_o        (resv_hit),
    .valid_o      (resv_valid)
  );

  assign accept  = start_i && (state_q == ST_IDLE);
  assign wdata_d = dec.dword ? rs2_val_i : {{UPPER_W{1'b0}}, rs2_val_i[31:0]};

  // Next state and outcome
  always_comb begin
    state_d  = state_q;
    res_en   = 1'b0;
    res_we_d = 1'b0;
    exc_d    = 1'b0;
    code_d   = '0;
    data_d   = '0;
    resv_set = 1'b0;
    sc_ok    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          res_en  = 1'b1;
          state_d = ST_DONE;
          if (!dec.legal) begin
            exc_d  = 1'b1;
            code_d = EXC_ILLEGAL;
          end else if (dec.misal) begin
            exc_d  = 1'b1;
            code_d = EXC_AMO_MISALIGN;
          end else if (xlat_fault_i) begin
            exc_d  = 1'b1;
            code_d = xlat_code_i;
          end else if (dec.is_sc && !resv_hit) begin
            res_we_d = 1'b1;
            data_d   = {{(XLEN-1){1'b0}}, 1'b1};
          end else begin
            res_en  = 1'b0;
            state_d = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (mem_req_ready_i) state_d = ST_RSP;
      end
      ST_RSP: begin
        if (mem_rsp_valid_i) begin
          res_en  = 1'b1;
          state_d = ST_DONE;
          if (mem_rsp_fault_i) begin
            exc_d  = 1'b1;
            code_d = is_sc_q ? EXC_AMO_FAULT : EXC_LOAD_FAULT;
          end else if (is_sc_q) begin
            res_we_d = 1'b1;
            sc_ok    = 1'b1;
          end else begin
            res_we_d = 1'b1;
            resv_set = 1'b1;
            data_d   = dword_q ? mem_rsp_rdata_i
                               : {{UPPER_W{mem_rsp_rdata_i[31]}}, mem_rsp_rdata_i[31:0]};
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign resv_clr = sc_ok || trap_entry_i || xret_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      paddr_q <= '0;
      wdata_q <= '0;
      is_sc_q <= 1'b0;
      dword_q <= 1'b0;
      aq_q    <= 1'b0;
      rl_q    <= 1'b0;
      rd_q    <= '0;
    end else if (accept) begin
      vaddr_q <= rs1_val_i;
      paddr_q <= xlat_paddr_i;
      wdata_q <= wdata_d;
      is_sc_q <= dec.is_sc;
      dword_q <= dec.dword;
      aq_q    <= dec.aq;
      rl_q    <= dec.rl;
      rd_q    <= dec.rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_we_q <= 1'b0;
      exc_q    <= 1'b0;
      code_q   <= '0;
      data_q   <= '0;
    end else if (res_en) begin
      res_we_q <= res_we_d;
      exc_q    <= exc_d;
      code_q   <= code_d;
      data_q   <= data_d;
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_DONE);
  assign rd_we_o         = done_o && res_we_q;
  assign exc_valid_o     = done_o && exc_q;
  assign rd_idx_o        = rd_q;
  assign rd_data_o       = data_q;
  assign exc_code_o      = code_q;

  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_write_o = is_sc_q;
  assign mem_req_dword_o = dword_q;
  assign mem_req_addr_o  = paddr_q;
  assign mem_req_wdata_o = wdata_q;
  assign mem_req_aq_o    = aq_q;
  assign mem_req_rl_o    = rl_q;
endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic            rd_we_o,
  input logic            exc_valid_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic            mem_req_write_o,
  input logic [XLEN-1:0] mem_req_addr_o,
  input logic [XLEN-1:0] mem_req_wdata_o,
  input logic            trap_entry_i,
  input logic            xret_i,
  input logic            resv_valid
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_wdata_o) && $stable(mem_req_write_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_valid_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we_o || exc_valid_o) |-> done_o);

  // R3
  wb_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_we_o && exc_valid_o));

  // R8
  cancel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_entry_i || xret_i) |=> !resv_valid);
endmodule

bind lrsc_unit lrsc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .rd_we_o         (rd_we_o),
  .exc_valid_o     (exc_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_write_o (mem_req_write_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o),
  .trap_entry_i    (trap_entry_i),
  .xret_i          (xret_i),
  .resv_valid      (resv_valid)
);

// File: tb/lrsc_unit_bench.sv
module lrsc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] rs1_val_i = '0;
  logic [63:0] rs2_val_i = '0;
  logic        xlat_fault_i = 1'b0;
  logic [4:0]  xlat_code_i = '0;
  logic [63:0] xlat_paddr_i = '0;
  logic        trap_entry_i = 1'b0;
  logic        xret_i = 1'b0;
  logic        mem_req_valid_o, mem_req_ready_i, mem_req_write_o, mem_req_dword_o;
  logic [63:0] mem_req_addr_o, mem_req_wdata_o;
  logic        mem_req_aq_o, mem_req_rl_o;
  logic        mem_rsp_valid_i, mem_rsp_fault_i;
  logic [63:0] mem_rsp_rdata_i;
  logic        busy_o, done_o, rd_we_o, exc_valid_o;
  logic [4:0]  rd_idx_o, exc_code_o;
  logic [63:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lrsc_unit u_lrsc_unit (.*);

  // Memory model
  logic [63:0] mem [16];
  int          stall_left = 0;
  logic        fault_next = 1'b0;
  logic        rsp_pending = 1'b0;
  logic        rsp_fault_q = 1'b0;
  logic [63:0] rsp_data_q = '0;
  int          nreq = 0;
  int          ndone = 0;
  logic [63:0] req_addr, req_wdata;
  logic        req_write, req_dword, req_aq, req_rl;

  initial begin
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_fault_i = 1'b0;
    mem_rsp_rdata_i = '0;
    for (int i = 0; i < 16; i++) mem[i] = 64'h0101_0101_0101_0101 * i;
  end

  always @(negedge clk) begin
    if (done_o) ndone++;
    if (rsp_pending) begin
      mem_rsp_valid_i = 1'b1;
      mem_rsp_fault_i = rsp_fault_q;
      mem_rsp_rdata_i = rsp_data_q;
      rsp_pending = 1'b0;
    end else begin
      mem_rsp_valid_i = 1'b0;
      mem_rsp_fault_i = 1'b0;
    end
    mem_req_ready_i = (stall_left == 0);
    if (mem_req_valid_o && !mem_req_ready_i) stall_left--;
    if (mem_req_valid_o && mem_req_ready_i) begin
      nreq++;
      req_addr = mem_req_addr_o; req_wdata = mem_req_wdata_o;
      req_write = mem_req_write_o; req_dword = mem_req_dword_o;
      req_aq = mem_req_aq_o; req_rl = mem_req_rl_o;
      rsp_fault_q = fault_next;
      fault_next = 1'b0;
      if (mem_req_dword_o) rsp_data_q = mem[mem_req_addr_o[6:3]];
      else if (mem_req_addr_o[2]) rsp_data_q = {32'h0, mem[mem_req_addr_o[6:3]][63:32]};
      else rsp_data_q = {32'h0, mem[mem_req_addr_o[6:3]][31:0]};
      if (mem_req_write_o && !rsp_fault_q) begin
        if (mem_req_dword_o) mem[mem_req_addr_o[6:3]] = mem_req_wdata_o;
        else if (mem_req_addr_o[2]) mem[mem_req_addr_o[6:3]][63:32] = mem_req_wdata_o[31:0];
        else mem[mem_req_addr_o[6:3]][31:0] = mem_req_wdata_o[31:0];
      end
      rsp_pending = 1'b1;
    end
  end

  // Captured outcome
  logic        got_done, got_we, got_exc;
  logic [63:0] got_data;
  logic [4:0]  got_code, got_rd;
  int          op_req, op_done;

  function automatic logic [31:0] enc(input logic [4:0] f5, input logic aq, input logic rl,
                                      input logic [4:0] rs2f, input logic [2:0] f3);
    return {f5, aq, rl, rs2f, 5'd10, f3, 5'd7, 7'b0101111};
  endfunction

  localparam logic [2:0] W = 3'b010;
  localparam logic [2:0] D = 3'b011;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [63:0] va, input logic [63:0] data2,
                     input logic xf, input logic [4:0] xc, input logic [63:0] pa, input logic poke);
    int req0, done0;
    req0 = nreq; done0 = ndone;
    got_done = 1'b0; got_we = 1'b0; got_exc = 1'b0; got_data = '0; got_code = '0; got_rd = '0;
    instr_i = ins; rs1_val_i = va; rs2_val_i = data2;
    xlat_fault_i = xf; xlat_code_i = xc; xlat_paddr_i = pa;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done_o) begin
        got_done = 1'b1; got_we = rd_we_o; got_exc = exc_valid_o;
        got_data = rd_data_o; got_code = exc_code_o; got_rd = rd_idx_o;
        break;
      end
      if (poke && i == 0) begin
        instr_i = 32'h0; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    op_req = nreq - req0;
    op_done = ndone - done0;
  endtask

  task automatic expect_rd(input string tag, input logic [63:0] val, input int reqs);
    chk(got_done && op_done == 1, {tag, " one done"}, 64'(op_done), 1);
    chk(got_we && !got_exc, {tag, " rd write"}, {62'd0, got_we, got_exc}, 64'h2);
    chk(got_data == val, {tag, " rd value"}, got_data, val);
    chk(op_req == reqs, {tag, " request count"}, 64'(op_req), 64'(reqs));
  endtask

  task automatic expect_exc(input string tag, input logic [4:0] code);
    chk(got_done && got_exc && !got_we, {tag, " exception"}, {62'd0, got_we, got_exc}, 64'h1);
    chk(got_code == code, {tag, " code"}, 64'(got_code), 64'(code));
    chk(op_req == 0, {tag, " no request"}, 64'(op_req), 0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o && !mem_req_valid_o, "R9 idle after reset",
        {61'd0, busy_o, done_o, mem_req_valid_o}, 0);
    run(enc(5'b00011, 0, 0, 5'd3, D), 64'h100, 64'h55, 0, 0, 64'h8, 0);
    expect_rd("R9 SC after reset fails", 64'd1, 0);
    chk(got_rd == 5'd7, "R9 rd index", 64'(got_rd), 7);
  endtask

  task automatic t_illegal;
    run(enc(5'b00010, 0, 0, 5'd0, 3'b000), 64'h100, 0, 0, 0, 64'h8, 0);
    expect_exc("R1 byte width", 5'd2);
    run(enc(5'b00010, 0, 0, 5'd4, D), 64'h100, 0, 0, 0, 64'h8, 0);
    expect_exc("R1 LR rs2 nonzero", 5'd2);
    run(enc(5'b00001, 0, 0, 5'd0, D), 64'h100, 0, 0, 0, 64'h8, 0);
    expect_exc("R1 other funct5", 5'd2);
  endtask

  task automatic t_misalign_xlat;
    run(enc(5'b00010, 0, 0, 5'd0, W), 64'h102, 0, 1, 5'd13, 64'h8, 0);
    expect_exc("R2 word misaligned over xlat fault", 5'd6);
    run(enc(5'b00011, 0, 0, 5'd3, D), 64'h104, 0, 0, 0, 64'h8, 0);
    expect_exc("R2 dword misaligned SC", 5'd6);
    run(enc(5'b00010, 0, 0, 5'd0, D), 64'h200, 0, 1, 5'd13, 64'h8, 0);
    expect_exc("R3 translation fault", 5'd13);
  endtask

  task automatic t_lr_sc;
    mem[8] = 64'h8765_4321_0FED_CBA9;
    run(enc(5'b00010, 0, 0, 5'd0, D), 64'h1000, 0, 0, 0, 64'h40, 0);
    expect_rd("R4 LR dword", 64'h8765_4321_0FED_CBA9, 1);
    chk(req_addr == 64'h40 && !req_write && req_dword, "R4 read request",
        req_addr, 64'h40);
    run(enc(5'b00010, 0, 0, 5'd0, W), 64'h2004, 0, 0, 0, 64'h44, 0);
    expect_rd("R4 LR word sign-extended", 64'hFFFF_FFFF_8765_4321, 1);
    chk(!req_dword, "R4 word size flag", {63'd0, req_dword}, 0);
    run(enc(5'b00011, 0, 0, 5'd3, W), 64'h2004, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 64'h48, 0);
    expect_rd("R6 SC word success", 64'd0, 1);
    chk(req_write && req_addr == 64'h48, "R6 write request", req_addr, 64'h48);
    chk(req_wdata == 64'h0000_0000_CAFE_F00D, "R6 word store data", req_wdata, 64'hCAFE_F00D);
    run(enc(5'b00011, 0, 0, 5'd3, W), 64'h2004, 64'h1, 0, 0, 64'h48, 0);
    expect_rd("R6 R5 SC after success fails", 64'd1, 0);
  endtask

  task automatic t_vaddr_key;
    run(enc(5'b00010, 0, 0, 5'd0, D), 64'h3000, 0, 0, 0, 64'h50, 0);
    run(enc(5'b00011, 0, 0, 5'd3, D), 64'h3008, 64'h9, 0, 0, 64'h50, 0);
    expect_rd("R5 SC address mismatch", 64'd1, 0);
    run(enc(5'b00011, 0, 0, 5'd3, D), 64'h3000, 64'h1122_3344_5566_7788, 0, 0, 64'h58, 0);
    expect_rd("R4 SC keyed on virtual address", 64'd0, 1);
    chk(req_wdata == 64'h1122_3344_5566_7788 && req_addr == 64'h58, "R6 dword store data",
        req_wdata, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_cancel;
    run(enc(5'b00010, 0, 0, 5'd0, D), 64'h4000, 0, 0, 0, 64'h60, 0);
    trap_entry_i = 1'b1; @(negedge clk); trap_entry_i = 1'b0;
    run(enc(5'b00011, 0, 0, 5'd3, D), 64'h4000, 64'h3, 0, 0, 64'h60, 0);
    expect_rd("R8 trap clears reservation", 64'd1, 0);
    run(enc(5'b00010, 0, 0, 5'd0, D), 64'h4000, 0, 0, 0, 64'h60, 0);
    xret_i = 1'b1; @(negedge clk); xret_i = 1'b0;
    run(enc(5'b00011, 0, 0, 5'd3, D), 64'h4000, 64'h3, 0, 0, 64'h60, 0);
    expect_rd("R8 xret clears reservation", 64'd1, 0);
  endtask

  task automatic t_fault;
    run(enc(5'b00010, 0, 0, 5'd0, D), 64'h5000, 0, 0, 0, 64'h68, 0);
    fault_next = 1'b1;
    run(enc(5'b00011, 0, 0, 5'd3, D), 64'h5000, 64'h4, 0, 0, 64'h68, 0);
    chk(got_exc && !got_we && got_code == 5'd7, "R7 SC access fault", 64'(got_code), 7);
    run(enc(5'b00011, 0, 0, 5'd3, D), 64'h5000, 64'h4, 0, 0, 64'h68, 0);
    expect_rd("R7 reservation kept after faulted SC", 64'd0, 1);
    fault_next = 1'b1;
    run(enc(5'b00010, 0, 0, 5'd0, W), 64'h6000, 0, 0, 0, 64'h70, 0);
    chk(got_exc && !got_we && got_code == 5'd5, "R7 LR access fault", 64'(got_code), 5);
  endtask

  task automatic t_stall;
    mem[15] = 64'h0BAD_F00D_1234_5678;
    stall_left = 3;
    run(enc(5'b00010, 1, 1, 5'd0, D), 64'h7000, 0, 0, 0, 64'h78, 1);
    expect_rd("R10 R11 stalled LR with busy poke", 64'h0BAD_F00D_1234_5678, 1);
    chk(req_aq && req_rl, "R10 aq rl passed", {62'd0, req_aq, req_rl}, 64'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_misalign_xlat();
    t_lr_sc();
    t_vaddr_key();
    t_cancel();
    t_fault();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule